// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator with Rotating Johnson Codewords

This block produces built-in self-test stimulus for a design with several scan chains while keeping the number of bit toggles low. A slowly advancing LFSR supplies a seed, and a single L-stage register does two jobs. In counting mode it steps through the Johnson sequence. In rotate mode it cycles its current vector past fixed taps. Each scan chain takes one tap, XORed with its own seed bit, so every chain is filled with a different rotation of the same Johnson vector.

A pulse on `start` begins a run. For each of the 2L Johnson vectors of a seed period, the register advances once and then rotates L times. Each rotation drives one scan word with scan enable high, and a one-cycle capture pulse follows each load. After 2L loads the seed advances. The run ends after the programmed number of seed periods, at which point `done` rises. The seed bits and the scan words together also drive the primary inputs of the circuit under test. All timing uses one clock, and the slow and fast steps are clock enables.

Top module: `msic_scan_tpg`

## Requirements
- R1: While `rst` is high, at each clock edge `scan_en`, `capture`, `done` and `scan_in` become 0, the Johnson register becomes all zeros, and the seed becomes `seed_init`, or 1 when `seed_init` is 0.
- R2: `start` seen high while the block is idle or done reloads the seed in the same way as R1, clears the Johnson register and clears `done`. `start` has no effect while a run is in progress.
- R3: The seed steps as seed_next = {seed[W-2:0], ^(seed & TAPS)}, with TAPS = 8'hB8 at the default W = 8. It steps only between seed periods and never becomes zero.
- R4: Before each scan load the Johnson register takes one counting step, J_next = {~J[0], J[L-1:1]}, where bit 0 is the LSB.
- R5: Each scan load lasts L consecutive cycles with `scan_en` = 1. In its k-th cycle (k from 0), `scan_in[i]` = R_k[i*(L/M)] ^ seed[i], where R_0 is the vector after the R4 step and R_{k+1} = {R_k[0], R_k[L-1:1]} (a rotate right).
- R6: In the cycle right after the last scan cycle of a load, `capture` is 1 for exactly one cycle and `scan_en` is 0. The two are never high together.
- R7: One seed period holds 2L loads. Between a capture and the next load there is one quiet cycle inside a period and two quiet cycles at a seed change. The run uses `seed_count` periods, and a count of 0 behaves as 1.
- R8: `done` rises in the cycle after the final capture and stays high, with no scan or capture activity, until the next accepted `start`.
- R9: `pi_drive` equals {`scan_in`, seed} at every cycle.
- R10: The first scan cycle is the third cycle after the edge that accepts `start`. The two cycles before it are quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or done |
| seed_init | input | W | Starting seed; 0 is replaced by 1 |
| seed_count | input | CW | Number of seed periods per run, latched at start |
| scan_in | output | M | One scan-in bit per chain |
| pi_drive | output | M+W | Primary-input stimulus {scan_in, seed} |
| scan_en | output | 1 | High while scan words are valid |
| capture | output | 1 | One-cycle capture pulse after each load |
| done | output | 1 | Run finished |

## Verification
The embedded properties take the reset to be synchronous and held for at least one edge. They also take `seed_init` to be stable while reset is high, because the seed is loaded from it at every reset edge. The bench changes inputs only at falling edges and sets `seed_init` and `seed_count` before it raises `start`. One directed run pulses `start` in the middle of a load to show that it is ignored. The table includes a zero seed and a zero period count, so that both substitutions are exercised.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_JSTEP, ST_SHIFT, ST_CAPT, ST_NSEED, ST_DONE
  } ctl_state_t;

  typedef enum logic [1:0] {
    JM_HOLD, JM_COUNT, JM_ROTATE, JM_CLEAR
  } jmode_t;
endpackage

// File: rtl/tpg_seed_lfsr.sv
module tpg_seed_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] init_val,
  output logic [W-1:0] seed
);
  logic [W-1:0] safe_init;
  assign safe_init = (init_val == '0) ? W'(1) : init_val;

  always_ff @(posedge clk) begin
    if (rst || load) seed <= safe_init;
    else if (adv)    seed <= {seed[W-2:0], ^(seed & TAPS)};
  end

  a_r3_seed_nonzero: assert property (@(posedge clk) disable iff (rst)
    seed != '0);
  a_r3_seed_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(seed));
endmodule

// File: rtl/tpg_johnson_reg.sv
module tpg_johnson_reg
  import tpg_pkg::*;
#(
  parameter int L = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  jmode_t       mode,
  output logic [L-1:0] jvec
);
  always_ff @(posedge clk) begin
    if (rst) jvec <= '0;
    else begin
      unique case (mode)
        JM_COUNT:  jvec <= {~jvec[0], jvec[L-1:1]};
        JM_ROTATE: jvec <= {jvec[0], jvec[L-1:1]};
        JM_CLEAR:  jvec <= '0;
        default:   jvec <= jvec;
      endcase
    end
  end

  a_r5_rotate_keeps_weight: assert property (@(posedge clk) disable iff (rst)
    (mode == JM_ROTATE) |=> ($countones(jvec) == $countones($past(jvec))));
  a_r4_count_changes_weight: assert property (@(posedge clk) disable iff (rst)
    (mode == JM_COUNT) |=> ($countones(jvec) != $countones($past(jvec))));
endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int L  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] seed_count,
  output jmode_t        jmode,
  output logic          seed_load,
  output logic          seed_adv,
  output logic          shift_act,
  output logic          capt_act,
  output logic          done_q
);
  localparam int KW = (L > 1) ? $clog2(L) : 1;
  localparam int VW = $clog2(2 * L + 1);
  localparam logic [KW-1:0] K_LAST = KW'(L - 1);
  localparam logic [VW-1:0] V_LAST = VW'(2 * L);

  ctl_state_t    state;
  logic [KW-1:0] kcnt;
  logic [VW-1:0] vcnt;
  logic [CW-1:0] scnt, total;
  logic          accept, last_seed;

  assign accept    = start && (state == ST_IDLE || state == ST_DONE);
  assign last_seed = ({1'b0, scnt} + (CW+1)'(1)) >= {1'b0, total};
  assign seed_load = accept;
  assign seed_adv  = (state == ST_NSEED) && !last_seed;
  assign shift_act = (state == ST_SHIFT);
  assign capt_act  = (state == ST_CAPT);

  always_comb begin
    if (accept)                   jmode = JM_CLEAR;
    else if (state == ST_JSTEP)   jmode = JM_COUNT;
    else if (state == ST_SHIFT)   jmode = JM_ROTATE;
    else                          jmode = JM_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      kcnt   <= '0;
      vcnt   <= '0;
      scnt   <= '0;
      total  <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (accept) begin
          state  <= ST_JSTEP;
          vcnt   <= '0;
          scnt   <= '0;
          total  <= seed_count;
          done_q <= 1'b0;
        end
        ST_JSTEP: begin
          vcnt  <= vcnt + 1'b1;
          kcnt  <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          kcnt <= kcnt + 1'b1;
          if (kcnt == K_LAST) state <= ST_CAPT;
        end
        ST_CAPT: state <= (vcnt == V_LAST) ? ST_NSEED : ST_JSTEP;
        ST_NSEED: begin
          if (last_seed) begin
            state  <= ST_DONE;
            done_q <= 1'b1;
          end else begin
            scnt  <= scnt + 1'b1;
            vcnt  <= '0;
            state <= ST_JSTEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_vector_bound: assert property (@(posedge clk) disable iff (rst)
    vcnt <= V_LAST);
  a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && start) |=> (state == ST_SHIFT || state == ST_CAPT));
endmodule

// File: rtl/msic_scan_tpg.sv
module msic_scan_tpg
  import tpg_pkg::*;
#(
  parameter int M  = 4,
  parameter int L  = 8,
  parameter int W  = 8,
  parameter int CW = 16,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  seed_init,
  input  logic [CW-1:0] seed_count,
  output logic [M-1:0]  scan_in,
  output logic [M+W-1:0] pi_drive,
  output logic          scan_en,
  output logic          capture,
  output logic          done
);
  localparam int STRIDE = L / M;

  jmode_t       jmode;
  logic         seed_load, seed_adv, shift_act, capt_act, done_q;
  logic [W-1:0] seed;
  logic [L-1:0] jvec;
  logic [M-1:0] mix;

  tpg_ctrl #(.L(L), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .seed_count(seed_count),
    .jmode(jmode), .seed_load(seed_load), .seed_adv(seed_adv),
    .shift_act(shift_act), .capt_act(capt_act), .done_q(done_q)
  );

  tpg_seed_lfsr #(.W(W), .TAPS(TAPS)) u_seed (
    .clk(clk), .rst(rst), .load(seed_load), .adv(seed_adv),
    .init_val(seed_init), .seed(seed)
  );

  tpg_johnson_reg #(.L(L)) u_john (
    .clk(clk), .rst(rst), .mode(jmode), .jvec(jvec)
  );

  for (genvar i = 0; i < M; i++) begin : g_xor
    assign mix[i] = jvec[i * STRIDE] ^ seed[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_in <= '0;
      scan_en <= 1'b0;
      capture <= 1'b0;
    end else begin
      scan_en <= shift_act;
      capture <= capt_act;
      if (shift_act) scan_in <= mix;
    end
  end

  assign done     = done_q;
  assign pi_drive = {scan_in, seed};

  a_r6_capture_after_load: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> capture);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(scan_en && capture));
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!scan_en && !capture));
endmodule

// File: tb/tb_msic_scan_tpg.sv
module tb_msic_scan_tpg;
  localparam int M = 4, L = 8, W = 8, CW = 16;
  localparam int STRIDE = L / M;
  localparam logic [W-1:0] TAPS = 8'hB8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] seed_init = 8'h5A;
  logic [CW-1:0] seed_count = '0;
  logic [M-1:0] scan_in;
  logic [M+W-1:0] pi_drive;
  logic scan_en, capture, done;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  msic_scan_tpg #(.M(M), .L(L), .W(W), .CW(CW), .TAPS(TAPS)) dut (
    .clk(clk), .rst(rst), .start(start), .seed_init(seed_init),
    .seed_count(seed_count), .scan_in(scan_in), .pi_drive(pi_drive),
    .scan_en(scan_en), .capture(capture), .done(done)
  );

  // table rows: {seed_init, seed_count}
  localparam int NCASE = 4;
  localparam logic [W+CW-1:0] CASES [NCASE] = '{
    {8'hA5, 16'd2}, {8'h01, 16'd1}, {8'h00, 16'd1}, {8'h3C, 16'd0}
  };

  function automatic logic [L-1:0] jstep(input logic [L-1:0] j);
    return {~j[0], j[L-1:1]};
  endfunction
  function automatic logic [L-1:0] jrot(input logic [L-1:0] j);
    return {j[0], j[L-1:1]};
  endfunction
  function automatic logic [W-1:0] snext(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    check(!scan_en && !capture, req, {capture, scan_en}, 0);
  endtask

  task automatic run_case(input logic [W-1:0] si, input logic [CW-1:0] sc,
                          input bit poke);
    logic [W-1:0] s;
    logic [L-1:0] j, r;
    logic [M-1:0] w;
    int nseed;
    seed_init = si;
    seed_count = sc;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R2 done cleared", done, 0);
    quiet("R10 first quiet");
    @(negedge clk) quiet("R10 second quiet");
    s = (si == '0) ? W'(1) : si;
    j = '0;
    nseed = (sc == '0) ? 1 : int'(sc);
    for (int p = 0; p < nseed; p++) begin
      for (int v = 0; v < 2 * L; v++) begin
        j = jstep(j);            // R4
        r = j;
        for (int k = 0; k < L; k++) begin
          @(negedge clk);
          check(scan_en == 1'b1, "R5 scan_en", scan_en, 1);
          for (int i = 0; i < M; i++) w[i] = r[i * STRIDE] ^ s[i];
          check(scan_in == w, "R5 scan word", scan_in, w);
          check(pi_drive == {w, s}, "R9 pi_drive", pi_drive, {w, s});
          if (poke && p == 0 && v == 0) start = (k == 2);  // R2 ignored while busy
          r = jrot(r);
        end
        @(negedge clk);
        check(capture == 1'b1 && scan_en == 1'b0, "R6 capture pulse",
              {capture, scan_en}, 2);
        if (p == nseed - 1 && v == 2 * L - 1) begin
          @(negedge clk);
          check(done == 1'b1, "R8 done rises", done, 1);
          quiet("R8 quiet at done");
        end else if (v == 2 * L - 1) begin
          @(negedge clk) quiet("R7 seed gap 1");
          @(negedge clk) quiet("R7 seed gap 2");
          s = snext(s);          // R3
        end else begin
          @(negedge clk) quiet("R7 vector gap");
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(scan_en == 0 && capture == 0 && done == 0, "R1 reset flags",
          {scan_en, capture, done}, 0);
    check(pi_drive == {{M{1'b0}}, 8'h5A}, "R1 reset seed/scan_in",
          pi_drive, {{M{1'b0}}, 8'h5A});
    @(negedge clk) rst = 1'b0;

    for (int c = 0; c < NCASE; c++)
      run_case(CASES[c][W+CW-1:CW], CASES[c][CW-1:0], 1'b0);

    // R8 done holds with no activity
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check(done == 1'b1, "R8 done holds", done, 1);
      quiet("R8 no activity");
    end

    // R2 start pulse in the middle of a load is ignored
    run_case(8'hC3, 16'd1, 1'b1);
    // R2 restart after done reloads seed and clears Johnson register
    run_case(8'hC3, 16'd1, 1'b0);

    // R1 reset from done
    @(negedge clk) begin rst = 1'b1; seed_init = 8'h00; end
    @(negedge clk);
    check(done == 0 && pi_drive == {{M{1'b0}}, 8'h01}, "R1 reset zero seed",
          {done, pi_drive}, {1'b0, {M{1'b0}}, 8'h01});
    @(negedge clk) rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule